// File: doc/BRIEF.md
# Branch Fault Retry Controller

This block governs the enable of one load-switch branch. It watches an overcurrent comparator bit and an over-temperature bit, qualifies a fault only when it persists, opens the switch, waits out a cooldown, and then either re-closes the switch after a growing backoff or gives up and stays open. Branches flagged as critical give up on the first qualified fault. A branch that has given up stays open until an explicit clear command arrives.

Every trip, every failed retry and every escalation to the open-and-held state produces a log record on a valid/ready stream. The record carries the fault kind, the retry count at that moment and the state the branch moved into. A consumer may hold off the stream; the controller never stalls its protection decisions for it. A record still waiting when a newer one is produced is replaced by the newer one.

The retry count is exposed at all times. It returns to zero after the branch has run fault-free for a configurable interval, so isolated faults far apart never use up the budget.

Top module: `branch_retry_ctrl`

## Requirements
- R1: While and after reset the state code is 0 (running), the switch enable is 1, the retry count is 0 and log_valid_o is 0.
- R2: A fault (oc_i or ot_i high) trips the branch only when sampled high on QUAL_CYC+1 consecutive clock edges (one in the running state, QUAL_CYC in the qualifying state, code 1); a shorter pulse returns the branch to running and the switch enable never drops.
- R3: State codes are running 0, qualifying 1, trip 2, cooldown 3, backoff 4, held-off 5, re-arm 6; trip and re-arm last one cycle each; the switch enable is 1 in codes 0, 1, 6 and 0 in codes 2 to 5.
- R4: The cooldown lasts COOL_CYC cycles after an overcurrent trip and 2*COOL_CYC cycles after an over-temperature trip; the trip counts as over-temperature when ot_i is high on the qualifying edge.
- R5: When the cooldown ends, the branch goes to backoff if the retry count is below RETRY_BUDGET, otherwise to held-off; the retry count never exceeds RETRY_BUDGET.
- R6: The first backoff lasts BACKOFF_BASE cycles and each later one twice the previous, capped at BACKOFF_CAP; leaving backoff increments the retry count and enters re-arm, which always leads to running.
- R7: With critical_i high in the trip cycle the branch goes straight to held-off with no cooldown or backoff.
- R8: Held-off is left only when clear_i is high, into re-arm, with the retry count cleared and the backoff back at BACKOFF_BASE; clear_i has no effect in any other state.
- R9: RECOVER_CYC consecutive fault-free edges in the running state clear the retry count and restore the backoff to BACKOFF_BASE.
- R10: Each trip cycle emits a record with kind 1 (overcurrent) or 2 (over-temperature), the retry count and the next state code (3 or 5); escalation from cooldown to held-off emits kind 3 (budget used up) with the retry count and state 5; the record is valid from the following cycle.
- R11: log_valid_o stays high with an unchanged payload until log_ready_i is sampled high; a new record replaces a pending one; acceptance with no new record lowers log_valid_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_i | input | 1 | Overcurrent comparator bit |
| ot_i | input | 1 | Over-temperature bit |
| clear_i | input | 1 | Clear command that releases a held-off branch |
| critical_i | input | 1 | Branch belongs to the critical group |
| log_ready_i | input | 1 | Log consumer accepts the record |
| sw_en_o | output | 1 | Load-switch enable |
| state_o | output | 3 | State code |
| retry_cnt_o | output | CW | Retries taken since the last clear or recovery |
| log_valid_o | output | 1 | Log record valid |
| log_type_o | output | 2 | Record kind: 1 overcurrent, 2 over-temperature, 3 budget used up |
| log_count_o | output | CW | Retry count carried by the record |
| log_state_o | output | 3 | State code the branch moved into |

## Verification
The assertions take the fault, clear, critical and ready inputs as synchronous, known values that may change on any cycle; they assume nothing about pulse length or spacing, and the critical bit is read only in the trip cycle. The stimulus changes every input only at the falling clock edge, draws fault bursts of short and long length, rare clears and critical changes, and a randomly gated ready, all from a seeded generator, so glitches, repeated trips, budget exhaustion and stream back-pressure all arise without any input ever being unknown.

// File: rtl/branch_retry_pkg.sv
package branch_retry_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_QUAL    = 3'd1,
    ST_TRIP    = 3'd2,
    ST_COOL    = 3'd3,
    ST_BACKOFF = 3'd4,
    ST_HELD    = 3'd5,
    ST_REARM   = 3'd6
  } brs_state_e;

  typedef enum logic [1:0] {
    LK_NONE    = 2'd0,
    LK_OC      = 2'd1,
    LK_OT      = 2'd2,
    LK_EXHAUST = 2'd3
  } brs_kind_e;
endpackage

// File: rtl/brs_timer.sv
module brs_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && cnt_q != '0)
      cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/brs_backoff.sv
module brs_backoff #(
  parameter int W    = 5,
  parameter int BASE = 4,
  parameter int CAP  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         grow,
  input  logic         restore,
  output logic [W-1:0] ival
);
  generate
    if (CAP <= BASE) begin : g_fixed
      assign ival = W'(BASE);
    end else begin : g_grow
      logic [W-1:0] ival_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          ival_q <= W'(BASE);
        else if (restore)
          ival_q <= W'(BASE);
        else if (grow) begin
          if (ival_q >= W'(CAP / 2))
            ival_q <= W'(CAP);
          else
            ival_q <= ival_q << 1;
        end
      end
      assign ival = ival_q;
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{clk, rst_n, grow, restore};
endmodule

// File: rtl/brs_recover.sv
module brs_recover #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet,
  output logic hit
);
  localparam int RW = $clog2(LIMIT + 1);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!quiet)
      cnt_q <= '0;
    else if (cnt_q != RW'(LIMIT))
      cnt_q <= cnt_q + RW'(1);
  end

  assign hit = quiet && (cnt_q == RW'(LIMIT - 1));
endmodule

// File: rtl/brs_log.sv
module brs_log #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [1:0]    kind_in,
  input  logic [CW-1:0] count_in,
  input  logic [2:0]    state_in,
  input  logic          ready,
  output logic          valid,
  output logic [1:0]    kind,
  output logic [CW-1:0] count,
  output logic [2:0]    fstate
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      kind   <= '0;
      count  <= '0;
      fstate <= '0;
    end else if (push) begin
      valid  <= 1'b1;
      kind   <= kind_in;
      count  <= count_in;
      fstate <= state_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_retry_ctrl.sv
module branch_retry_ctrl
  import branch_retry_pkg::*;
#(
  parameter int QUAL_CYC     = 3,
  parameter int COOL_CYC     = 6,
  parameter int BACKOFF_BASE = 4,
  parameter int BACKOFF_CAP  = 16,
  parameter int RECOVER_CYC  = 20,
  parameter int RETRY_BUDGET = 3,
  parameter int CW           = $clog2(RETRY_BUDGET + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oc_i,
  input  logic          ot_i,
  input  logic          clear_i,
  input  logic          critical_i,
  input  logic          log_ready_i,
  output logic          sw_en_o,
  output logic [2:0]    state_o,
  output logic [CW-1:0] retry_cnt_o,
  output logic          log_valid_o,
  output logic [1:0]    log_type_o,
  output logic [CW-1:0] log_count_o,
  output logic [2:0]    log_state_o
);
  localparam int COOL_OT = 2 * COOL_CYC;
  localparam int T_A     = (COOL_OT > BACKOFF_CAP) ? COOL_OT : BACKOFF_CAP;
  localparam int TMAX    = (T_A > QUAL_CYC) ? T_A : QUAL_CYC;
  localparam int TW      = $clog2(TMAX + 1);
  localparam logic [TW-1:0] QUAL_LOAD    = TW'(QUAL_CYC - 1);
  localparam logic [TW-1:0] COOL_OC_LOAD = TW'(COOL_CYC - 1);
  localparam logic [TW-1:0] COOL_OT_LOAD = TW'(COOL_OT - 1);

  brs_state_e    st_q, st_d;
  brs_kind_e     fkind_q, fkind_d;
  logic [CW-1:0] retry_q, retry_d;

  logic          fault;
  logic          tmr_load, tmr_dec, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          bo_grow, bo_restore;
  logic [TW-1:0] bo_ival;
  logic          rec_hit;
  logic          lg_push;
  brs_kind_e     lg_kind;
  brs_state_e    lg_state;

  assign fault = oc_i | ot_i;

  brs_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .dec(tmr_dec), .zero(tmr_zero)
  );

  brs_backoff #(.W(TW), .BASE(BACKOFF_BASE), .CAP(BACKOFF_CAP)) u_backoff (
    .clk(clk), .rst_n(rst_n), .grow(bo_grow), .restore(bo_restore), .ival(bo_ival)
  );

  brs_recover #(.LIMIT(RECOVER_CYC)) u_recover (
    .clk(clk), .rst_n(rst_n), .quiet((st_q == ST_RUN) && !fault), .hit(rec_hit)
  );

  always_comb begin
    st_d       = st_q;
    fkind_d    = fkind_q;
    retry_d    = retry_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    tmr_dec    = 1'b0;
    bo_grow    = 1'b0;
    bo_restore = 1'b0;
    lg_push    = 1'b0;
    lg_kind    = LK_NONE;
    lg_state   = ST_RUN;
    unique case (st_q)
      ST_RUN: begin
        if (fault) begin
          st_d     = ST_QUAL;
          tmr_load = 1'b1;
          tmr_val  = QUAL_LOAD;
        end else if (rec_hit) begin
          retry_d    = '0;
          bo_restore = 1'b1;
        end
      end
      ST_QUAL: begin
        if (!fault)
          st_d = ST_RUN;
        else if (tmr_zero) begin
          st_d    = ST_TRIP;
          fkind_d = ot_i ? LK_OT : LK_OC;
        end else
          tmr_dec = 1'b1;
      end
      ST_TRIP: begin
        lg_push = 1'b1;
        lg_kind = fkind_q;
        if (critical_i) begin
          st_d     = ST_HELD;
          lg_state = ST_HELD;
        end else begin
          st_d     = ST_COOL;
          lg_state = ST_COOL;
          tmr_load = 1'b1;
          tmr_val  = (fkind_q == LK_OT) ? COOL_OT_LOAD : COOL_OC_LOAD;
        end
      end
      ST_COOL: begin
        if (tmr_zero) begin
          if (retry_q >= CW'(RETRY_BUDGET)) begin
            st_d     = ST_HELD;
            lg_push  = 1'b1;
            lg_kind  = LK_EXHAUST;
            lg_state = ST_HELD;
          end else begin
            st_d     = ST_BACKOFF;
            tmr_load = 1'b1;
            tmr_val  = bo_ival - TW'(1);
          end
        end else
          tmr_dec = 1'b1;
      end
      ST_BACKOFF: begin
        if (tmr_zero) begin
          st_d    = ST_REARM;
          retry_d = retry_q + CW'(1);
          bo_grow = 1'b1;
        end else
          tmr_dec = 1'b1;
      end
      ST_HELD: begin
        if (clear_i) begin
          st_d       = ST_REARM;
          retry_d    = '0;
          bo_restore = 1'b1;
        end
      end
      ST_REARM: st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      fkind_q <= LK_OC;
      retry_q <= '0;
    end else begin
      st_q    <= st_d;
      fkind_q <= fkind_d;
      retry_q <= retry_d;
    end
  end

  brs_log #(.CW(CW)) u_log (
    .clk(clk), .rst_n(rst_n), .push(lg_push), .kind_in(lg_kind),
    .count_in(retry_q), .state_in(lg_state), .ready(log_ready_i),
    .valid(log_valid_o), .kind(log_type_o), .count(log_count_o),
    .fstate(log_state_o)
  );

  assign sw_en_o     = (st_q == ST_RUN) || (st_q == ST_QUAL) || (st_q == ST_REARM);
  assign state_o     = st_q;
  assign retry_cnt_o = retry_q;
endmodule

// File: rtl/branch_retry_ctrl_chk.sv
module branch_retry_ctrl_chk #(
  parameter int RETRY_BUDGET = 3,
  parameter int CW           = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oc_i,
  input logic          ot_i,
  input logic          clear_i,
  input logic          critical_i,
  input logic          log_ready_i,
  input logic          sw_en_o,
  input logic [2:0]    state_o,
  input logic [CW-1:0] retry_cnt_o,
  input logic          log_valid_o
);
  localparam logic [2:0] C_RUN = 3'd0, C_QUAL = 3'd1, C_TRIP = 3'd2, C_COOL = 3'd3,
                         C_BACK = 3'd4, C_HELD = 3'd5, C_REARM = 3'd6;

  assert_quiet_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_RUN && !oc_i && !ot_i) |=> (state_o == C_RUN));

  assert_qual_exits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_QUAL) |=> (state_o == C_RUN || state_o == C_QUAL || state_o == C_TRIP));

  assert_switch_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_TRIP || state_o == C_COOL || state_o == C_BACK || state_o == C_HELD) |-> !sw_en_o);

  assert_budget_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt_o <= CW'(RETRY_BUDGET));

  assert_rearm_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_REARM) |=> (state_o == C_RUN));

  assert_critical_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_TRIP && critical_i) |=> (state_o == C_HELD));

  assert_held_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_HELD && !clear_i) |=> (state_o == C_HELD));

  assert_clear_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_HELD && clear_i) |=> (state_o == C_REARM && retry_cnt_o == '0));

  assert_trip_logs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == C_TRIP) |=> log_valid_o);

  assert_log_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (log_valid_o && !log_ready_i) |=> log_valid_o);
endmodule

bind branch_retry_ctrl branch_retry_ctrl_chk #(.RETRY_BUDGET(RETRY_BUDGET), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oc_i(oc_i), .ot_i(ot_i), .clear_i(clear_i),
  .critical_i(critical_i), .log_ready_i(log_ready_i), .sw_en_o(sw_en_o),
  .state_o(state_o), .retry_cnt_o(retry_cnt_o), .log_valid_o(log_valid_o)
);

// File: tb/branch_retry_ctrl_test.sv
module branch_retry_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 3, COOL = 6, BASE = 4, CAP = 16, REC = 20, BUDGET = 3;
  localparam int CW = $clog2(BUDGET + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic oc_i = 0, ot_i = 0, clear_i = 0, critical_i = 0, log_ready_i = 1;
  logic sw_en_o, log_valid_o;
  logic [2:0] state_o, log_state_o;
  logic [1:0] log_type_o;
  logic [CW-1:0] retry_cnt_o, log_count_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  branch_retry_ctrl #(.QUAL_CYC(QUAL), .COOL_CYC(COOL), .BACKOFF_BASE(BASE),
    .BACKOFF_CAP(CAP), .RECOVER_CYC(REC), .RETRY_BUDGET(BUDGET)) uut (
    .clk(clk), .rst_n(rst_n), .oc_i(oc_i), .ot_i(ot_i), .clear_i(clear_i),
    .critical_i(critical_i), .log_ready_i(log_ready_i), .sw_en_o(sw_en_o),
    .state_o(state_o), .retry_cnt_o(retry_cnt_o), .log_valid_o(log_valid_o),
    .log_type_o(log_type_o), .log_count_o(log_count_o), .log_state_o(log_state_o));

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model of the requirements
  int ms, mt, mr, mb, mrc, mf, mv, mk, mc, mst;
  int ns, nt, nr, nb, nf, pk, pst;
  bit flt, quiet, hit, push;

  function automatic int dbl(int b);
    return (b * 2 > CAP) ? CAP : b * 2;
  endfunction

  function automatic int cool_len(int kind);
    return (kind == 2) ? 2 * COOL : COOL;
  endfunction

  function automatic string tag_for(int s);
    case (s)
      1: return "R2";
      3: return "R4";
      4: return "R6";
      5: return "R8";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mt = 0; mr = 0; mb = BASE; mrc = 0; mf = 1; mv = 0; mk = 0; mc = 0; mst = 0;
    end else begin
      flt = oc_i || ot_i;
      quiet = (ms == 0) && !flt;
      hit = quiet && (mrc == REC - 1);
      ns = ms; nt = mt; nr = mr; nb = mb; nf = mf; push = 0; pk = 0; pst = 0;
      case (ms)
        0: if (flt) begin ns = 1; nt = QUAL - 1; end
           else if (hit) begin nr = 0; nb = BASE; end
        1: if (!flt) ns = 0;
           else if (mt == 0) begin ns = 2; nf = ot_i ? 2 : 1; end
           else nt = mt - 1;
        2: begin
             push = 1; pk = mf;
             if (critical_i) begin ns = 5; pst = 5; end
             else begin ns = 3; pst = 3; nt = cool_len(mf) - 1; end
           end
        3: if (mt == 0) begin
             if (mr >= BUDGET) begin ns = 5; push = 1; pk = 3; pst = 5; end
             else begin ns = 4; nt = mb - 1; end
           end else nt = mt - 1;
        4: if (mt == 0) begin ns = 6; nr = mr + 1; nb = dbl(mb); end
           else nt = mt - 1;
        5: if (clear_i) begin ns = 6; nr = 0; nb = BASE; end
        default: ns = 0;
      endcase
      if (push) begin mv = 1; mk = pk; mc = mr; mst = pst; end
      else if (mv != 0 && log_ready_i) mv = 0;
      mrc = !quiet ? 0 : ((mrc == REC) ? REC : mrc + 1);
      ms = ns; mt = nt; mr = nr; mb = nb; mf = nf;
    end
  end

  // Observation
  int prev_st = 0, run = 0;
  int cool_q[$], boff_q[$], kind_q[$];
  int last_kind = 0, last_cnt = 0, last_st = 0;

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk(int'(state_o) == ms, tag_for(ms), "state", state_o, ms);
      chk(int'(sw_en_o) == ((ms == 0 || ms == 1 || ms == 6) ? 1 : 0), "R3", "sw_en",
          sw_en_o, (ms == 0 || ms == 1 || ms == 6) ? 1 : 0);
      chk(int'(retry_cnt_o) == mr, "R5", "retry", retry_cnt_o, mr);
      chk(int'(log_valid_o) == mv, "R11", "log_valid", log_valid_o, mv);
      if (mv != 0) begin
        chk(int'(log_type_o) == mk, "R10", "log_type", log_type_o, mk);
        chk(int'(log_count_o) == mc, "R10", "log_count", log_count_o, mc);
        chk(int'(log_state_o) == mst, "R10", "log_state", log_state_o, mst);
      end
      if (log_valid_o && log_ready_i) begin
        kind_q.push_back(int'(log_type_o));
        last_kind = log_type_o; last_cnt = log_count_o; last_st = log_state_o;
      end
      if (int'(state_o) != prev_st) begin
        if (prev_st == 3) cool_q.push_back(run);
        if (prev_st == 4) boff_q.push_back(run);
        run = 1; prev_st = state_o;
      end else run++;
    end
  endtask

  task automatic wait_state(int s, int lim, string tag);
    for (int i = 0; i < lim && int'(state_o) != s; i++) tick();
    chk(int'(state_o) == s, tag, "reach state", state_o, s);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit sw_dropped;
    int burst;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R1", "reset state", state_o, 0);
    chk(sw_en_o == 1'b1, "R1", "reset sw_en", sw_en_o, 1);
    chk(retry_cnt_o == '0, "R1", "reset retry", retry_cnt_o, 0);
    chk(log_valid_o == 1'b0, "R1", "reset log_valid", log_valid_o, 0);
    rst_n = 1'b1;
    tick();

    // R2: pulse one edge short of qualification
    oc_i = 1; sw_dropped = 0;
    for (int i = 0; i < QUAL; i++) begin tick(); if (!sw_en_o) sw_dropped = 1; end
    oc_i = 0;
    for (int i = 0; i < 3; i++) begin tick(); if (!sw_en_o) sw_dropped = 1; end
    chk(!sw_dropped, "R2", "switch dropped on short pulse", sw_dropped, 0);
    chk(state_o == 3'd0, "R2", "back to running", state_o, 0);

    // R8: clear while running has no effect
    clear_i = 1; tick(); tick(); clear_i = 0; tick();
    chk(state_o == 3'd0, "R8", "clear in running state", state_o, 0);
    chk(retry_cnt_o == '0, "R8", "clear in running retry", retry_cnt_o, 0);

    // R4 R5 R6 R10: persistent overcurrent exhausts the budget
    cool_q.delete(); boff_q.delete(); kind_q.delete();
    oc_i = 1;
    wait_state(5, 400, "R5");
    tick(); tick();
    oc_i = 0;
    chk(cool_q.size() == BUDGET + 1, "R4", "cooldown count", cool_q.size(), BUDGET + 1);
    foreach (cool_q[i]) chk(cool_q[i] == COOL, "R4", "oc cooldown length", cool_q[i], COOL);
    chk(boff_q.size() == BUDGET, "R6", "backoff count", boff_q.size(), BUDGET);
    if (boff_q.size() == BUDGET) begin
      chk(boff_q[0] == 4, "R6", "backoff 1", boff_q[0], 4);
      chk(boff_q[1] == 8, "R6", "backoff 2", boff_q[1], 8);
      chk(boff_q[2] == 16, "R6", "backoff 3", boff_q[2], 16);
    end
    chk(kind_q.size() == BUDGET + 2, "R10", "record count", kind_q.size(), BUDGET + 2);
    chk(last_kind == 3, "R10", "exhaust kind", last_kind, 3);
    chk(last_cnt == BUDGET, "R10", "exhaust count", last_cnt, BUDGET);
    chk(last_st == 5, "R10", "exhaust state", last_st, 5);
    chk(retry_cnt_o == CW'(BUDGET), "R5", "retry at exhaustion", retry_cnt_o, BUDGET);

    // R8 release, R4 over-temperature cooldown, R9 recovery
    clear_i = 1; tick(); clear_i = 0; tick();
    chk(state_o == 3'd0, "R8", "released to running", state_o, 0);
    chk(retry_cnt_o == '0, "R8", "retry cleared", retry_cnt_o, 0);
    cool_q.delete();
    ot_i = 1;
    wait_state(3, 50, "R4");
    ot_i = 0;
    wait_state(0, 100, "R6");
    chk(cool_q.size() == 1 && cool_q[0] == 2 * COOL, "R4", "ot cooldown length",
        cool_q.size() ? cool_q[0] : -1, 2 * COOL);
    chk(retry_cnt_o == 1, "R6", "retry after one retry", retry_cnt_o, 1);
    for (int i = 0; i < 15; i++) tick();
    chk(retry_cnt_o == 1, "R9", "retry kept before interval", retry_cnt_o, 1);
    for (int i = 0; i < 10; i++) tick();
    chk(retry_cnt_o == '0, "R9", "retry cleared by recovery", retry_cnt_o, 0);

    // R7: critical branch holds off at the first trip
    cool_q.delete();
    critical_i = 1; oc_i = 1;
    wait_state(5, 50, "R7");
    oc_i = 0; tick();
    chk(cool_q.size() == 0, "R7", "no cooldown for critical", cool_q.size(), 0);
    chk(last_kind == 1 && last_st == 5, "R7", "critical record state", last_st, 5);

    // R11: back-pressure hold and replacement
    log_ready_i = 0;
    clear_i = 1; tick(); clear_i = 0;
    oc_i = 1; wait_state(5, 50, "R7"); oc_i = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(log_valid_o == 1'b1, "R11", "held valid", log_valid_o, 1);
      chk(log_type_o == 2'd1, "R11", "held kind", log_type_o, 1);
    end
    clear_i = 1; tick(); clear_i = 0;
    ot_i = 1; wait_state(5, 50, "R7"); ot_i = 0; tick();
    chk(log_type_o == 2'd2, "R11", "replaced kind", log_type_o, 2);
    log_ready_i = 1; tick(); tick();
    chk(log_valid_o == 1'b0, "R11", "valid drops after accept", log_valid_o, 0);
    critical_i = 0;
    clear_i = 1; tick(); clear_i = 0; tick();

    // Random phase
    burst = 0;
    for (int c = 0; c < 6000; c++) begin
      if (burst == 0 && ($urandom % 16) == 0) begin
        burst = (($urandom % 8) == 0) ? 60 + $urandom % 80 : 1 + $urandom % 8;
        if ($urandom % 3 == 0) begin ot_i = 1; oc_i = 0; end
        else begin oc_i = 1; ot_i = 0; end
      end
      if (burst > 0) burst--;
      if (burst == 0) begin oc_i = 0; ot_i = 0; end
      clear_i = (($urandom % 50) == 0);
      if (($urandom % 700) == 0) critical_i = ~critical_i;
      log_ready_i = (($urandom % 4) != 0);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule